// File: doc/BRIEF.md
# Synchronous FIFO with watermark flags

This block is a single-clock first-in first-out buffer. Words presented with a write strobe are stored in an inferred two-port memory array and come back, in the order they went in, when the read strobe is raised. A write pointer and a read pointer walk the array and wrap modulo its depth. A stored-word counter is exported so the surrounding logic always knows how much data is held.

Status is reported by five flags. Empty and full come from a small occupancy state machine with three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Its transitions are *fill* (`ST_EMPTY` to `ST_PARTIAL` on an accepted write), *top-up* (`ST_PARTIAL` to `ST_FULL` when a lone write lands on the last free slot), *unload* (`ST_FULL` to `ST_PARTIAL` on an accepted read) and *drain* (`ST_PARTIAL` to `ST_EMPTY` when a lone read takes the last word). Every other case is a hold in the current state.

Two watermark flags, almost-full and almost-empty, give early warning at depths that are set by parameters. A one-cycle error pulse marks any write refused because the buffer is full and any read refused because it is empty. Data width, address width and both watermark depths are compile-time parameters. Reset is asynchronous and active low.

Top module: `wm_fifo`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first access, `empty`=1, `full`=0, `count`=0, `err`=0 and `rd_data`=0.
- R2: Accepted words are read back in exactly the order they were written.
- R3: `count` equals the number of stored words. It never exceeds DEPTH = 2^ADDR_W and goes up by one per accepted write and down by one per accepted read.
- R4: `empty` is 1 exactly when `count`=0, and `full` is 1 exactly when `count`=DEPTH.
- R5: `almost_full` is 1 exactly when `count` >= DEPTH-AF_GAP, and `almost_empty` is 1 exactly when `count` <= AE_LEVEL. So `almost_full` is already high when `full` rises, and `almost_empty` is already high when `empty` rises.
- R6: `err` is 1 in the cycle after a clock edge that sampled `wr_en` with `full`=1 or `rd_en` with `empty`=1. At any other time it is 0.
- R7: A write while full is refused: `count` and the stored contents are unchanged, so later reads return only the earlier words.
- R8: A read while empty is refused: `rd_data` and `count` keep their values.
- R9: A read and a write in the same cycle both take effect when the buffer is neither full nor empty, and `count` stays the same. When empty, only the write is done and `err` pulses. When full, only the read is done and `err` pulses.
- R10: `rd_data` is registered. The word taken by an accepted read appears after the clock edge that sampled `rd_en`, and it holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| count | output | ADDR_W+1 | Number of stored words |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| almost_empty | output | 1 | count <= AE_LEVEL |
| almost_full | output | 1 | count >= DEPTH-AF_GAP |
| err | output | 1 | One-cycle pulse after a refused access |

## Verification
Every result of this block is due one clock edge after the request that causes it. `count`, `empty`, `full`, both watermarks, `err` and the `rd_data` of an accepted read all change on that edge, because all of them come straight from registers. The driver applies each request on a falling edge and updates its model at that moment. The monitor samples 1 ns after the next rising edge and compares every output against the model, popping the scoreboard queue only for reads the model accepted. In every cycle without an accepted read, `rd_data` is compared with the last word read, which covers the hold required by R8 and R10.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/wm_fifo_ctrl.sv
module wm_fifo_ctrl
    import wm_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W:0]   count,
    output logic              empty,
    output logic              full,
    output logic              err
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'((1 << ADDR_W) - 1);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    occ_state_e state_q, state_d;

    // A request is accepted only in a state that allows it.
    always_comb begin
        wr_ok = wr_en && (state_q != ST_FULL);
        rd_ok = rd_en && (state_q != ST_EMPTY);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:   if (wr_en) state_d = ST_PARTIAL;                      // fill
            ST_PARTIAL: begin
                if (wr_ok && !rd_ok && count == LAST_C) state_d = ST_FULL;   // top-up
                else if (rd_ok && !wr_ok && count == ONE_C) state_d = ST_EMPTY; // drain
            end
            ST_FULL:    if (rd_en) state_d = ST_PARTIAL;                      // unload
            default:    state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Datapath registers: pointers, counter, error pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            err    <= 1'b0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            if (wr_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !wr_ok) count <= count - 1'b1;
            err <= (wr_en && !wr_ok) || (rd_en && !rd_ok);
        end
    end

    // Output decode from the state register.
    always_comb begin
        empty = (state_q == ST_EMPTY);
        full  = (state_q == ST_FULL);
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
    a_r4_empty_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (count == '0));
    a_r4_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (count == DEPTH_C));
    a_r7_full_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> ($stable(count) && $stable(wr_ptr)));
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en && full) || (rd_en && empty)) |=> err);
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !((wr_en && full) || (rd_en && empty)) |=> !err);
endmodule

// File: rtl/wm_fifo_mem.sv
module wm_fifo_mem #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/wm_fifo_flags.sv
module wm_fifo_flags #(
    parameter int ADDR_W   = 4,
    parameter int AF_GAP   = 4,
    parameter int AE_LEVEL = 4
) (
    input  logic [ADDR_W:0] count,
    output logic            almost_full,
    output logic            almost_empty
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] AF_LIM = CNT_W'((1 << ADDR_W) - AF_GAP);
    localparam logic [CNT_W-1:0] AE_LIM = CNT_W'(AE_LEVEL);

    always_comb begin
        almost_full  = (count >= AF_LIM);
        almost_empty = (count <= AE_LIM);
    end
endmodule

// File: rtl/wm_fifo.sv
module wm_fifo #(
    parameter int DATA_W   = 24,
    parameter int ADDR_W   = 4,
    parameter int AF_GAP   = 4,
    parameter int AE_LEVEL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W:0]   count,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              err
);
    logic              wr_ok, rd_ok;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;

    wm_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .count(count), .empty(empty), .full(full), .err(err)
    );

    wm_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
        .re(rd_ok), .raddr(rd_ptr), .rdata(rd_data)
    );

    wm_fifo_flags #(.ADDR_W(ADDR_W), .AF_GAP(AF_GAP), .AE_LEVEL(AE_LEVEL)) u_flags (
        .count(count), .almost_full(almost_full), .almost_empty(almost_empty)
    );

    a_r5_full_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);
    a_r5_empty_implies_ae: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);
    a_r8_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rd_data));
    a_r9_both_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !empty && !full) |=> $stable(count));
endmodule

// File: tb/wm_fifo_tb.sv
module wm_fifo_tb;
    localparam int DATA_W = 24;
    localparam int ADDR_W = 4;
    localparam int AF_GAP = 4;
    localparam int AE_LEVEL = 4;
    localparam int DEPTH = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W:0] count;
    logic empty, full, almost_empty, almost_full, err;

    always #2 clk = ~clk;

    wm_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AF_GAP(AF_GAP), .AE_LEVEL(AE_LEVEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .count(count), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full), .err(err)
    );

    int vectors = 0;
    int miscompares = 0;
    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] sb_q[$];
    int   exp_cnt = 0;
    bit   exp_err = 0;
    bit   exp_rd_act = 0;
    bit   mon_en = 0;
    logic [DATA_W-1:0] last_rd = '0;
    string phase = "reset";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s phase=%s actual=%0h expected=%0h", req, phase, act, exp);
        end
    endtask

    // Driver: one request per cycle, applied on the falling edge.
    task automatic cyc(bit w, bit r, logic [DATA_W-1:0] d);
        bit w_ok, r_ok;
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
        w_ok = w && (exp_cnt < DEPTH);
        r_ok = r && (exp_cnt > 0);
        exp_err = (w && exp_cnt == DEPTH) || (r && exp_cnt == 0);
        exp_rd_act = r_ok;
        if (r_ok) sb_q.push_back(model_q.pop_front());
        if (w_ok) model_q.push_back(d);
        exp_cnt = exp_cnt + int'(w_ok) - int'(r_ok);
        mon_en = 1;
    endtask

    // Monitor: results are due one edge after the request.
    always @(posedge clk) begin
        #1;
        if (mon_en) begin
            if (exp_rd_act) begin
                last_rd = sb_q.pop_front();
                chk("R2/R10 read data", 32'(rd_data), 32'(last_rd));
            end else begin
                chk("R8/R10 rd_data hold", 32'(rd_data), 32'(last_rd));
            end
            chk("R3 count", 32'(count), 32'(exp_cnt));
            chk("R4 empty", 32'(empty), 32'(exp_cnt == 0));
            chk("R4 full", 32'(full), 32'(exp_cnt == DEPTH));
            chk("R5 almost_full", 32'(almost_full), 32'(exp_cnt >= DEPTH - AF_GAP));
            chk("R5 almost_empty", 32'(almost_empty), 32'(exp_cnt <= AE_LEVEL));
            chk("R6 err", 32'(err), 32'(exp_err));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is held.
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 count", 32'(count), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 rd_data", 32'(rd_data), 32'd0);
        rst_n = 1'b1;
        // R1: still idle after release; the monitor checks each idle cycle.
        phase = "R1_idle";
        cyc(0, 0, '0);
        cyc(0, 0, '0);
        // R8: read while empty is refused.
        phase = "R8_empty_read";
        cyc(0, 1, '0);
        // R9: read and write together while empty: only the write is done.
        phase = "R9_empty_both";
        cyc(1, 1, 24'hA00001);
        // Fill to full, walking through both watermarks.
        phase = "R5_fill";
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 24'hB00000 + 24'(i));
        // R7: write while full is refused; contents are checked by the drain.
        phase = "R7_full_write";
        cyc(1, 0, 24'hDEAD00);
        cyc(1, 0, 24'hDEAD01);
        // R9: read and write together while full: only the read is done.
        phase = "R9_full_both";
        cyc(1, 1, 24'hC00001);
        // Drain completely, then try one read too many.
        phase = "R2_drain";
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1, '0);
        // R9: read and write together in the partial state.
        phase = "R9_partial_both";
        cyc(1, 0, 24'h111111);
        cyc(1, 0, 24'h222222);
        for (int i = 0; i < 6; i++) cyc(1, 1, 24'h300000 + 24'(i));
        // Mixed traffic with pointer wrap.
        phase = "R3_mixed";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv = $urandom;
            cyc(rv[0] | rv[1], rv[2] | rv[3] & rv[4], rv[31:8]);
        end
        phase = "R2_final_drain";
        for (int i = 0; i < DEPTH + 1; i++) cyc(0, 1, '0);
        cyc(0, 0, '0);
        @(negedge clk);
        mon_en = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule